// File: doc/BRIEF.md
# SPI Burst Shift Engine

This engine is the serial heart of an SPI controller. It takes 32-bit words from a transmit FIFO, shifts their active bits out on MOSI with the most significant bit first, and at the same time collects MISO bits into 32-bit receive words that it hands to a receive FIFO. A programmable burst length, in bits, may be shorter than one word or span many words. Only the first word of a burst is partial: it carries the burst length modulo 32 bits, and every later word carries a full 32 bits.

Software sets the burst-length field, raises the enable, fills the transmit FIFO and pulses start. The engine then keeps popping and shifting until the transmit FIFO runs dry. If the FIFO empties part way through a burst, the remaining count is kept, and the next start carries on from that point. Dropping the enable aborts any transfer and clears the engine's internal state. Register decoding, chip selects and FIFO storage are handled outside the engine.

Top module: `spi_burst_shifter`

## Requirements
- R1: The effective burst length in bits is the burst-length field plus one, rounded up to the next multiple of 8 (for example, a field of 11 gives 16 bits and a field of 32 gives 40 bits).
- R2: For each word popped, the engine shifts (remaining burst mod 32) bits, or 32 bits when that remainder is zero. When the remaining burst reaches zero, it is reloaded from the field at the next pop.
- R3: A word that carries N bits is sent as tx_data bits N-1 down to 0, in that order on MOSI. Bits above N-1 are never sent.
- R4: Received bits shift into the receive word from bit 0 upward, so the first bit received ends up at bit N-1 and bits above N-1 are zero. The word is offered on rx_data with a one-cycle rx_push at the falling SCLK edge that ends the transmit word.
- R5: SPI mode 0 applies. SCLK idles low. After each word is loaded, SCLK stays low for CLK_DIV clocks, then high for CLK_DIV clocks, and so on. MISO is sampled on the rising edge, and MOSI changes only at a falling edge or at a load.
- R6: A pop happens only when tx_empty is low. The first pop needs enable and start. After the first pop, a further word is popped at the end of each word for as long as the FIFO is not empty. Otherwise the engine goes idle.
- R7: If the FIFO runs dry before a burst is complete, the next start continues the same burst with the remaining bit count, instead of reloading the field.
- R8: At the end of a word, if rx_full is high, the word is dropped with no rx_push and rx_overflow is set. rx_overflow stays set until enable is lowered.
- R9: While enable is low, start is ignored and nothing is popped. Lowering enable stops SCLK and clears busy, rx_overflow and the remaining burst count on the next clock.
- R10: busy rises on the clock after the first pop and falls on the clock after the last word completes. After reset, sclk, mosi, busy, tx_pop, rx_push and rx_overflow are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable; low clears the internal state |
| start | input | 1 | Trigger that begins draining the transmit FIFO |
| burst_len | input | LEN_W | Burst length field, bits minus one |
| tx_data | input | 32 | Head word of the transmit FIFO (first-word fall-through) |
| tx_empty | input | 1 | Transmit FIFO is empty |
| tx_pop | output | 1 | Takes the head word of the transmit FIFO this cycle |
| rx_data | output | 32 | Assembled receive word |
| rx_push | output | 1 | Writes rx_data into the receive FIFO this cycle |
| rx_full | input | 1 | Receive FIFO is full |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| busy | output | 1 | A transfer is in progress |
| rx_overflow | output | 1 | Sticky flag: a receive word was dropped |

## Verification
The bench builds the engine with LEN_W = 8 and CLK_DIV = 3. The 8-bit field makes bursts of up to three words short enough to run many of them. An odd divider shows that the low and high SCLK phases each last exactly CLK_DIV clocks, rather than a fixed two. MISO is tied to the inverse of MOSI, so every received word can be predicted from the transmit word and its active bit count. This exposes errors in word splitting, bit order and receive alignment. Burst lengths of 8, 16, 24, 32, 40, 48 and 96 bits cover every partial first-word size, as well as reload across a burst boundary.

// File: rtl/spi_burst_shifter.sv
module spi_burst_shifter #(
  parameter int LEN_W   = 12,
  parameter int CLK_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic [LEN_W-1:0] burst_len,
  input  logic [31:0]      tx_data,
  input  logic             tx_empty,
  output logic             tx_pop,
  output logic [31:0]      rx_data,
  output logic             rx_push,
  input  logic             rx_full,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             rx_overflow
);

  localparam int REM_W = LEN_W + 1;
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic             running;
  logic             sclk_q;
  logic             ovf_q;
  logic [REM_W-1:0] rem_q;
  logic [5:0]       wbits_q;
  logic [5:0]       bits_q;
  logic [31:0]      tx_sh;
  logic [31:0]      rx_sh;
  logic [DIV_W-1:0] div_q;

  wire tick      = running && (div_q == DIV_W'(CLK_DIV - 1));
  wire rise      = tick && !sclk_q;
  wire fall      = tick && sclk_q;
  wire word_done = fall && (bits_q == 6'd1);

  // field + 1 rounded up to a byte multiple
  wire [REM_W-1:0] full_len = ({1'b0, burst_len} + REM_W'(8)) & ~REM_W'(7);
  wire [REM_W-1:0] rem_left = word_done ? (rem_q - REM_W'(wbits_q)) : rem_q;
  wire [REM_W-1:0] rem_eff  = (rem_left == '0) ? full_len : rem_left;
  wire [5:0]       wbits_n  = (rem_eff[4:0] == 5'd0) ? 6'd32 : {1'b0, rem_eff[4:0]};

  wire launch = enable && !running && start && !tx_empty;
  wire chain  = enable && word_done && !tx_empty;

  assign tx_pop      = launch || chain;
  assign rx_push     = enable && word_done && !rx_full;
  assign rx_data     = rx_sh;
  assign sclk        = sclk_q;
  assign mosi        = running && tx_sh[31];
  assign busy        = running;
  assign rx_overflow = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      sclk_q  <= 1'b0;
      ovf_q   <= 1'b0;
      rem_q   <= '0;
      wbits_q <= '0;
      bits_q  <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      div_q   <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      sclk_q  <= 1'b0;
      ovf_q   <= 1'b0;
      rem_q   <= '0;
      bits_q  <= '0;
      div_q   <= '0;
    end else begin
      if (running)
        div_q <= tick ? '0 : div_q + DIV_W'(1);
      if (rise) begin
        sclk_q <= 1'b1;
        rx_sh  <= {rx_sh[30:0], miso};
      end
      if (fall) begin
        sclk_q <= 1'b0;
        tx_sh  <= tx_sh << 1;
        bits_q <= bits_q - 6'd1;
      end
      if (word_done) begin
        rem_q <= rem_left;
        if (rx_full)
          ovf_q <= 1'b1;
        if (tx_empty)
          running <= 1'b0;
      end
      if (tx_pop) begin
        running <= 1'b1;
        div_q   <= '0;
        rem_q   <= rem_eff;
        wbits_q <= wbits_n;
        bits_q  <= wbits_n;
        tx_sh   <= tx_data << (6'd32 - wbits_n);
        rx_sh   <= '0;
      end
    end
  end

endmodule

// File: rtl/spi_burst_shifter_chk.sv
module spi_burst_shifter_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic start,
  input logic tx_empty,
  input logic tx_pop,
  input logic rx_full,
  input logic rx_push,
  input logic rx_overflow,
  input logic sclk,
  input logic mosi,
  input logic busy
);

  a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  a_r5_mosi_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> !tx_pop);

  a_r6_idle_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |-> !tx_pop);

  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_push);

  a_r8_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_overflow) |-> $past(rx_full));

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !rx_overflow && !sclk));

  a_r10_busy_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> busy);

endmodule

bind spi_burst_shifter spi_burst_shifter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
  .tx_empty(tx_empty), .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push),
  .rx_overflow(rx_overflow), .sclk(sclk), .mosi(mosi), .busy(busy)
);

// File: tb/test_spi_burst_shifter.sv
`timescale 1ns/1ps
module test_spi_burst_shifter;

  localparam int LW  = 8;
  localparam int DIV = 3;

  typedef struct packed {
    logic [7:0]  fld;
    logic [1:0]  n;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [31:0] w2;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{8'd7,  2'd1, 32'h000000A5, 32'h0, 32'h0},
    '{8'd31, 2'd1, 32'h12345678, 32'h0, 32'h0},
    '{8'd47, 2'd2, 32'hDEAD3C5A, 32'hC0FFEE11, 32'h0},
    '{8'd11, 2'd2, 32'h0000F00D, 32'h12348001, 32'h0},
    '{8'd32, 2'd2, 32'h777777E7, 32'h80000001, 32'h0},
    '{8'd23, 2'd1, 32'hFFABCDEF, 32'h0, 32'h0},
    '{8'd95, 2'd3, 32'h01234567, 32'h89ABCDEF, 32'hF0E1D2C3}
  };

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, start = 1'b0, rx_full = 1'b0;
  logic [LW-1:0] burst_len = '0;
  logic [31:0] tx_data, rx_data;
  logic tx_empty, tx_pop, rx_push, miso, sclk, mosi, busy, rx_overflow;

  logic [31:0] tx_mem [16];
  int tx_wr = 0, tx_rd = 0;
  logic bit_log [4096];
  int bit_n = 0;
  logic [31:0] rx_log [256];
  int rx_n = 0;

  int checks = 0, errors = 0;
  logic exp_bits [512];
  int exp_n;
  logic [31:0] exp_rx [16];
  int exp_rn;
  int m_rem = 0;

  always #2 clk = ~clk;

  assign tx_empty = (tx_wr == tx_rd);
  assign tx_data  = tx_mem[tx_rd % 16];
  assign miso     = ~mosi;

  always @(posedge clk) begin
    if (tx_pop) tx_rd <= tx_rd + 1;
    if (rx_push) begin
      rx_log[rx_n % 256] <= rx_data;
      rx_n <= rx_n + 1;
    end
  end

  always @(posedge sclk) begin
    bit_log[bit_n % 4096] <= mosi;
    bit_n <= bit_n + 1;
  end

  spi_burst_shifter #(.LEN_W(LW), .CLK_DIV(DIV)) i_spi_burst_shifter (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start), .burst_len(burst_len),
    .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop), .rx_data(rx_data),
    .rx_push(rx_push), .rx_full(rx_full), .miso(miso), .sclk(sclk), .mosi(mosi),
    .busy(busy), .rx_overflow(rx_overflow)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    tx_mem[tx_wr % 16] = w;
    tx_wr = tx_wr + 1;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy !== 1'b0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic model_word(input logic [7:0] fld, input logic [31:0] w);
    int wb;
    logic [31:0] mask;
    if (m_rem == 0) m_rem = ((int'(fld) + 1 + 7) / 8) * 8;
    wb = (m_rem % 32 == 0) ? 32 : m_rem % 32;
    for (int i = wb - 1; i >= 0; i--) begin
      exp_bits[exp_n] = w[i];
      exp_n++;
    end
    mask = (wb == 32) ? 32'hFFFFFFFF : ((32'h1 << wb) - 32'h1);
    exp_rx[exp_rn] = ~w & mask;
    exp_rn++;
    m_rem = m_rem - wb;
  endtask

  task automatic compare(input int b0, input int r0, input string tag);
    int bad = 0;
    chk(bit_n - b0 == exp_n, {tag, " bit count R1 R2"}, bit_n - b0, exp_n);
    for (int i = 0; i < exp_n; i++)
      if (bit_log[(b0 + i) % 4096] !== exp_bits[i]) bad++;
    chk(bad == 0, {tag, " MOSI order R3"}, bad, 0);
    chk(rx_n - r0 == exp_rn, {tag, " push count R4"}, rx_n - r0, exp_rn);
    for (int i = 0; i < exp_rn; i++)
      chk(rx_log[(r0 + i) % 256] === exp_rx[i], {tag, " rx word R4"},
          rx_log[(r0 + i) % 256], exp_rx[i]);
  endtask

  task automatic soft_reset();
    @(negedge clk) enable = 1'b0;
    @(negedge clk) enable = 1'b1;
    m_rem = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int b0, r0, rd0, cnt;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({sclk, mosi, busy, tx_pop, rx_push, rx_overflow} === 6'b0, "R10 reset outputs",
        {sclk, mosi, busy, tx_pop, rx_push, rx_overflow}, 0);
    rst_n = 1'b1;
    @(negedge clk) enable = 1'b1;

    // table of vectors (R1 R2 R3 R4 R6)
    for (int v = 0; v < 7; v++) begin
      burst_len = VECS[v].fld;
      exp_n = 0; exp_rn = 0; b0 = bit_n; r0 = rx_n;
      push_word(VECS[v].w0); model_word(VECS[v].fld, VECS[v].w0);
      if (VECS[v].n > 1) begin push_word(VECS[v].w1); model_word(VECS[v].fld, VECS[v].w1); end
      if (VECS[v].n > 2) begin push_word(VECS[v].w2); model_word(VECS[v].fld, VECS[v].w2); end
      pulse_start();
      wait_idle();
      compare(b0, r0, $sformatf("vec%0d", v));
      chk(tx_empty === 1'b1, "R6 drained FIFO", tx_empty, 1);
      soft_reset();
    end

    // R5 phase lengths
    burst_len = 8'd7;
    push_word(32'h5A);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy === 1'b1, "R10 busy after pop", busy, 1);
    cnt = 0;
    while (sclk === 1'b0 && cnt < 20) begin cnt++; @(negedge clk); end
    chk(cnt == DIV, "R5 low phase", cnt, DIV);
    cnt = 0;
    while (sclk === 1'b1 && cnt < 20) begin cnt++; @(negedge clk); end
    chk(cnt == DIV, "R5 high phase", cnt, DIV);
    wait_idle();
    soft_reset();

    // R6 start with empty FIFO
    pulse_start();
    @(negedge clk);
    chk(busy === 1'b0, "R6 empty start ignored", busy, 0);

    // R7 burst resumes across a dry FIFO
    burst_len = 8'd47;
    exp_n = 0; exp_rn = 0; b0 = bit_n; r0 = rx_n;
    push_word(32'hA1B2C3D4); model_word(8'd47, 32'hA1B2C3D4);
    pulse_start(); wait_idle();
    push_word(32'h0F1E2D3C); model_word(8'd47, 32'h0F1E2D3C);
    pulse_start(); wait_idle();
    compare(b0, r0, "R7 resume");
    soft_reset();

    // R8 overflow
    rx_full = 1'b1;
    burst_len = 8'd31;
    r0 = rx_n;
    push_word(32'hCAFEF00D);
    pulse_start(); wait_idle();
    chk(rx_n == r0, "R8 no push when full", rx_n - r0, 0);
    chk(rx_overflow === 1'b1, "R8 overflow set", rx_overflow, 1);
    rx_full = 1'b0;
    repeat (4) @(negedge clk);
    chk(rx_overflow === 1'b1, "R8 overflow sticky", rx_overflow, 1);
    soft_reset();
    chk(rx_overflow === 1'b0, "R9 overflow cleared", rx_overflow, 0);

    // R9 start ignored while disabled
    @(negedge clk) enable = 1'b0;
    push_word(32'h11223344);
    rd0 = tx_rd;
    pulse_start();
    @(negedge clk);
    chk(tx_rd == rd0 && busy === 1'b0, "R9 disabled start ignored", tx_rd - rd0, 0);

    // R9 abort mid transfer
    @(negedge clk) enable = 1'b1;
    pulse_start();
    repeat (5) @(negedge clk);
    chk(busy === 1'b1, "R10 busy during transfer", busy, 1);
    enable = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && sclk === 1'b0, "R9 abort", {busy, sclk}, 0);
    @(negedge clk) enable = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule